// File: doc/BRIEF.md
# Multi-Axis Step Pulse One-Shot

This block turns a single-cycle trigger into one step event on a group of motor axes. An upstream line tracer decides which axes step and in which direction. This block handles pin timing and nothing else. On an accepted trigger, the direction pins change first. After a lead interval, the step pins of the selected axes go active. After a programmed width, they return to their idle level.

Each of the two pin groups has its own polarity mask. Two self-stopping down-counters time the lead interval and the pulse width. Both counters run on the block clock, so the pulse length does not depend on the rate at which triggers arrive.

A trigger that arrives while an event is still in progress is dropped. It also sets a sticky overrun flag, which reset clears.

Top module: `step_pulse_gen`

## Requirements
- R1: While the synchronous active-low reset is asserted, each clock edge loads `step_o` with `step_inv_i`, loads `dir_o` with `dir_inv_i`, and clears `overrun_o`.
- R2: At the clock edge where an idle block samples `trig_i` high, `dir_o` takes `dir_bits_i ^ dir_inv_i`. At that edge `step_o` stays at the idle level `step_inv_i`, so direction always changes before any step edge.
- R3: With `lead_en_i` low, the step pins go active exactly one clock after the direction update.
- R4: With `lead_en_i` high, the step pins go active exactly D clocks after the direction update. D is `lead_len_i`, and a value of 0 counts as 1. Trigger-to-pulse-end time is therefore D plus the pulse width.
- R5: During the pulse, bit i of `step_o` equals `step_bits_i[i] ^ step_inv_i[i]` as captured at the trigger. Axes whose step bit was 0 stay at their idle level. The pulse lasts exactly W clocks, where W is `pulse_len_i` and a value of 0 counts as 1.
- R6: At pulse end, `step_o` returns to `step_inv_i` and `dir_o` is left unchanged. Until the next accepted trigger, no further step edge occurs and `dir_o` holds.
- R7: A trigger sampled while a lead or pulse interval is active is ignored. It sets `overrun_o`, and `overrun_o` stays set until reset.
- R8: Step bits, direction bits, lead count and width count are all sampled at the accepted trigger. Changing them later does not affect the event in progress.
- R9: While idle, `step_o` follows `step_inv_i` with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Step event request, sampled on each edge |
| step_bits_i | input | NAXES | Axes that step in this event |
| dir_bits_i | input | NAXES | Direction for each axis in this event |
| lead_en_i | input | 1 | Enables the programmable direction-to-step lead |
| lead_len_i | input | CNT_W | Lead length in clocks (0 counts as 1) |
| pulse_len_i | input | CNT_W | Pulse width in clocks (0 counts as 1) |
| step_inv_i | input | NAXES | Step polarity mask; also the idle level |
| dir_inv_i | input | NAXES | Direction polarity mask |
| step_o | output | NAXES | Step pins |
| dir_o | output | NAXES | Direction pins |
| overrun_o | output | 1 | Sticky flag: a trigger was dropped while busy |

## Verification
The assertions check several properties on every cycle:
- The lead and pulse intervals never overlap.
- Each counter stops by itself once it fires.
- The direction pins hold throughout a busy interval.
- The step pins stay idle during the lead.
- The overrun flag, once set, never clears outside reset.

Some behaviour only the bench scenarios can show:
- The exact cycle of the step edge and of the pulse end for each lead and width value, including the zero-as-one cases.
- The per-axis pattern of the pins under both polarity masks.
- That values changed after the trigger have no effect on the event in progress.

// File: rtl/spg_pkg.sv
package spg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LEAD  = 2'd1,
      PH_PULSE = 2'd2
   } spg_phase_e;

   function automatic spg_phase_e phase_of(input logic lead_run, input logic pulse_run);
      if (pulse_run)     return PH_PULSE;
      else if (lead_run) return PH_LEAD;
      else               return PH_IDLE;
   endfunction

endpackage

// File: rtl/spg_oneshot.sv
module spg_oneshot #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             running,
   output logic             fire
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign running = (cnt_q != '0);
   assign fire    = (cnt_q == CNT_W'(1));

   // R6
   self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load) |=> !running);

   // R5
   nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));

endmodule

// File: rtl/spg_pins.sv
module spg_pins #(
   parameter int NAXES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NAXES-1:0] step_inv,
   input  logic [NAXES-1:0] dir_inv,
   input  logic             dir_load,
   input  logic [NAXES-1:0] dir_val,
   input  logic             step_set,
   input  logic             step_hold,
   input  logic [NAXES-1:0] step_val,
   output logic [NAXES-1:0] step_o,
   output logic [NAXES-1:0] dir_o
);

   for (genvar a = 0; a < NAXES; a++) begin : g_axis
      always_ff @(posedge clk) begin
         if (!rst_n)        dir_o[a] <= dir_inv[a];
         else if (dir_load) dir_o[a] <= dir_val[a] ^ dir_inv[a];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)         step_o[a] <= step_inv[a];
         else if (step_set)  step_o[a] <= step_val[a] ^ step_inv[a];
         else if (!step_hold) step_o[a] <= step_inv[a];
      end
   end

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen #(
   parameter int NAXES = 3,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic [NAXES-1:0] step_bits_i,
   input  logic [NAXES-1:0] dir_bits_i,
   input  logic             lead_en_i,
   input  logic [CNT_W-1:0] lead_len_i,
   input  logic [CNT_W-1:0] pulse_len_i,
   input  logic [NAXES-1:0] step_inv_i,
   input  logic [NAXES-1:0] dir_inv_i,
   output logic [NAXES-1:0] step_o,
   output logic [NAXES-1:0] dir_o,
   output logic             overrun_o
);
   import spg_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (NAXES < 1) begin : g_bad_axes
      $error("step_pulse_gen: NAXES must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("step_pulse_gen: CNT_W must be at least 2");
   end

   logic             lead_run, lead_fire, pulse_run, pulse_fire;
   logic             accept;
   spg_phase_e       phase;
   logic [CNT_W-1:0] lead_eff, width_eff, width_q;
   logic [NAXES-1:0] bits_q;
   logic             ovr_q;

   assign phase     = phase_of(lead_run, pulse_run);
   assign accept    = trig_i && (phase == PH_IDLE);
   assign lead_eff  = (!lead_en_i || lead_len_i == '0) ? ONE : lead_len_i;
   assign width_eff = (pulse_len_i == '0) ? ONE : pulse_len_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q <= ONE;
         bits_q  <= '0;
      end else if (accept) begin
         width_q <= width_eff;
         bits_q  <= step_bits_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           ovr_q <= 1'b0;
      else if (trig_i && phase != PH_IDLE)  ovr_q <= 1'b1;
   end
   assign overrun_o = ovr_q;

   spg_oneshot #(.CNT_W(CNT_W)) u_lead (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(lead_eff),
      .running(lead_run), .fire(lead_fire)
   );

   spg_oneshot #(.CNT_W(CNT_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .load(lead_fire), .load_val(width_q),
      .running(pulse_run), .fire(pulse_fire)
   );

   spg_pins #(.NAXES(NAXES)) u_pins (
      .clk(clk), .rst_n(rst_n),
      .step_inv(step_inv_i), .dir_inv(dir_inv_i),
      .dir_load(accept), .dir_val(dir_bits_i),
      .step_set(lead_fire), .step_hold(pulse_run && !pulse_fire),
      .step_val(bits_q),
      .step_o(step_o), .dir_o(dir_o)
   );

   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_run && pulse_run));

   // R6
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(dir_o));

   // R2
   lead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_run && !lead_fire) |=> (step_o == $past(step_inv_i)));

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && phase != PH_IDLE) |=> overrun_o);

endmodule

// File: tb/tb_step_pulse_gen.sv
module tb_step_pulse_gen;
   localparam int N = 3;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         trig_i;
   logic [N-1:0] step_bits_i, dir_bits_i, step_inv_i, dir_inv_i;
   logic         lead_en_i;
   logic [W-1:0] lead_len_i, pulse_len_i;
   logic [N-1:0] step_o, dir_o;
   logic         overrun_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   step_pulse_gen #(.NAXES(N), .CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
      .step_bits_i(step_bits_i), .dir_bits_i(dir_bits_i),
      .lead_en_i(lead_en_i), .lead_len_i(lead_len_i), .pulse_len_i(pulse_len_i),
      .step_inv_i(step_inv_i), .dir_inv_i(dir_inv_i),
      .step_o(step_o), .dir_o(dir_o), .overrun_o(overrun_o)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_pulse(input logic [N-1:0] sb, input logic [N-1:0] db,
                            input logic le, input int ld, input int wd, input bit disturb);
      int d;
      int w;
      logic [N-1:0] exp;
      d = (le && ld > 0) ? ld : 1;
      w = (wd > 0) ? wd : 1;
      @(negedge clk);
      step_bits_i = sb; dir_bits_i = db; lead_en_i = le;
      lead_len_i = W'(ld); pulse_len_i = W'(wd); trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      check(32'(dir_o), 32'(db ^ dir_inv_i), "R2 dir at trigger");
      check(32'(step_o), 32'(step_inv_i), "R2 step idle at trigger");
      if (disturb) begin
         // R8: changed after the trigger, must not matter
         step_bits_i = ~sb; dir_bits_i = ~db;
         lead_len_i = W'(ld + 3); pulse_len_i = W'(wd + 3);
      end
      for (int k = 1; k <= d + w; k++) begin
         trig_i = (disturb && k == 1);
         @(negedge clk);
         exp = (k >= d && k < d + w) ? (sb ^ step_inv_i) : step_inv_i;
         if (k == d)
            check(32'(step_o), 32'(exp), le ? "R4 step edge after lead" : "R3 step edge one clock after dir");
         else if (k == d + w)
            check(32'(step_o), 32'(exp), "R6 pulse end restores idle");
         else
            check(32'(step_o), 32'(exp), disturb ? "R8 R5 pulse shape" : "R5 pulse shape");
         check(32'(dir_o), 32'(db ^ dir_inv_i), "R6 dir held");
      end
      trig_i = 1'b0;
      @(negedge clk);
      check(32'(step_o), 32'(step_inv_i), "R6 no further step edge");
      check(32'(dir_o), 32'(db ^ dir_inv_i), "R6 dir held after end");
   endtask

   initial begin
      int n;
      rst_n = 1'b0; trig_i = 1'b0; step_bits_i = '0; dir_bits_i = '0;
      lead_en_i = 1'b0; lead_len_i = '0; pulse_len_i = '0;
      step_inv_i = 3'b101; dir_inv_i = 3'b010;
      repeat (3) @(negedge clk);
      check(32'(step_o), 32'(3'b101), "R1 reset step");
      check(32'(dir_o), 32'(3'b010), "R1 reset dir");
      check(32'(overrun_o), 0, "R1 reset overrun");
      rst_n = 1'b1;
      @(negedge clk);

      // R9 idle follows the step mask
      step_inv_i = 3'b011;
      @(negedge clk);
      check(32'(step_o), 32'(3'b011), "R9 idle follows mask");
      step_inv_i = 3'b000;
      @(negedge clk);
      check(32'(step_o), 32'(3'b000), "R9 idle follows mask");

      n = 0;
      for (int pol = 0; pol < 2; pol++) begin
         step_inv_i = pol ? 3'b110 : 3'b000;
         dir_inv_i  = pol ? 3'b011 : 3'b000;
         for (int le = 0; le < 2; le++)
            for (int ld = 0; ld < 4; ld++)
               for (int wd = 0; wd < 4; wd++) begin
                  run_pulse(N'(n + 1), N'(n * 5 + 2), le[0], ld, wd, 1'b0);
                  n++;
               end
      end
      check(32'(overrun_o), 0, "R7 no overrun without busy trigger");

      // R7 and R8: a busy trigger is dropped and inputs change mid-event
      run_pulse(3'b101, 3'b110, 1'b1, 2, 3, 1'b1);
      check(32'(overrun_o), 1, "R7 overrun set");
      run_pulse(3'b011, 3'b001, 1'b0, 0, 2, 1'b0);
      check(32'(overrun_o), 1, "R7 overrun sticky");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(32'(overrun_o), 0, "R1 overrun cleared by reset");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule